// File: doc/BRIEF.md
# Four-Lane Dual-Width Byte Buffer

This block stores transfer data between a register bus and a serial shift engine. It holds four byte-wide FIFOs of equal depth, called lanes, and offers two bus ports in each direction. The word port moves one byte through every lane in a single access. The byte port moves one byte through lane 0 only. A single `word_mode` input selects the port width for the current transfer. In word mode the buffer holds four times as much data as in byte mode.

On the transmit side the bus writes and the serial engine pops a byte stream. In word mode the stream rotates through the lanes, lane 0 first, so each word leaves least significant byte first. In byte mode the stream comes only from lane 0. The receive side is the mirror image. The serial engine pushes bytes, rotating through the lanes in word mode and into lane 0 in byte mode. The bus then reads whole words or single bytes.

A bus access that cannot be served is dropped and produces a one-cycle `illegal` pulse. This covers a write when the buffer is full, a read when no data is available, and any use of the port width that does not match `word_mode`. A soft clear empties every lane.

Top module: `quad_lane_fifo`

## Requirements
- R1: Each lane holds at most DEPTH (16) bytes. The usable capacity is 16 words (64 bytes) in word mode and 16 bytes in byte mode. An accepted write never overwrites stored data.
- R2: In word mode a word write stores bits [7:0] in lane 0, [15:8] in lane 1, [23:16] in lane 2 and [31:24] in lane 3. The serial transmit stream then presents the bytes in lane order 0, 1, 2, 3, with `ser_tx_valid` low whenever the next lane in turn is empty.
- R3: In byte mode a byte write goes to lane 0, and the serial transmit stream drains lane 0 alone in write order.
- R4: In word mode, received serial bytes fill lanes 0, 1, 2, 3 in rotation. `rx_word_avail` is high only while all four lanes hold a byte. `rd_word` then returns the oldest four bytes, the first received in bits [7:0].
- R5: In byte mode, received serial bytes go to lane 0. `rx_byte_avail` is high while lane 0 holds a byte, and `rd_byte` returns the bytes in arrival order.
- R6: `tx_full` is high when the active port cannot take another write: any lane is full in word mode, or lane 0 is full in byte mode. `tx_half` is high at 32 or more stored bytes in word mode, or at 8 or more bytes in lane 0 in byte mode. `tx_empty` is high when all lanes are empty. Every flag reflects an access in the cycle after its clock edge.
- R7: These bus accesses are dropped and raise `illegal` for exactly the cycle after the access edge: a write while `tx_full` is high, a word read while `rx_word_avail` is low, a byte read while `rx_byte_avail` is low, or a port whose width disagrees with `word_mode`.
- R8: `soft_clr` empties every lane of both directions and restarts lane rotation at lane 0. Any access in the same cycle is ignored and raises no `illegal`.
- R9: `ser_rx_ready` is low when the receive lane next in turn is full. A serial push in that state is dropped.
- R10: After reset the buffer is empty: `tx_empty`=1, `tx_full`=0, `tx_half`=0, both receive available flags are 0, `ser_tx_valid`=0, `ser_rx_ready`=1 and `illegal`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Empty all lanes and restart rotation |
| word_mode | input | 1 | 1 = word port width, 0 = byte port width |
| wr_word_en | input | 1 | Transmit word write strobe |
| wr_word | input | 32 | Transmit word data, lane 0 in [7:0] |
| wr_byte_en | input | 1 | Transmit byte write strobe |
| wr_byte | input | 8 | Transmit byte data |
| tx_full | output | 1 | Transmit side cannot accept a write on the active port |
| tx_half | output | 1 | Transmit side at least half of active capacity |
| tx_empty | output | 1 | All transmit lanes empty |
| ser_tx_pop | input | 1 | Serial engine takes the presented transmit byte |
| ser_tx_valid | output | 1 | A transmit byte is presented |
| ser_tx_data | output | 8 | Presented transmit byte |
| ser_rx_push | input | 1 | Serial engine delivers a received byte |
| ser_rx_data | input | 8 | Received byte |
| ser_rx_ready | output | 1 | Receive lane next in turn has room |
| rd_word_en | input | 1 | Receive word read strobe |
| rd_word | output | 32 | Oldest receive word, lane 0 in [7:0] |
| rd_byte_en | input | 1 | Receive byte read strobe |
| rd_byte | output | 8 | Oldest byte of receive lane 0 |
| rx_word_avail | output | 1 | Every receive lane holds a byte |
| rx_byte_avail | output | 1 | Receive lane 0 holds a byte |
| illegal | output | 1 | One-cycle pulse after a dropped bus access |

## Verification
All outputs come from registered state alone, so the flags, the presented bytes and the read data show the effect of an access one cycle after its edge. `illegal` is itself a register and pulses in that same following cycle. The bench drives every stimulus at the falling edge, updates its lane model at once, and compares every output with the model at the next falling edge. A check is therefore always made exactly one edge after the access it reflects, and never races the rising edge.

// File: rtl/qlf_pkg.sv
package qlf_pkg;

    localparam int LANES_DEF = 4;
    localparam int LANE_W_DEF = 8;
    localparam int DEPTH_DEF = 16;

    typedef enum logic {
        W_BYTE = 1'b0,
        W_WORD = 1'b1
    } width_e;

    typedef struct packed {
        logic wr_word;
        logic wr_byte;
        logic rd_word;
        logic rd_byte;
    } acc_bad_t;

    // Lane that follows 'cur' in the serial rotation for the given width.
    function automatic int unsigned lane_after(int unsigned cur, int unsigned lanes, width_e w);
        if (w == W_BYTE) return 0;
        if (cur + 1 >= lanes) return 0;
        return cur + 1;
    endfunction

endpackage

// File: rtl/qlf_lane.sv
module qlf_lane #(
    parameter int W = 8,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign dout    = mem[rp];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    p_full_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> full);

endmodule

// File: rtl/qlf_tx_path.sv
module qlf_tx_path
    import qlf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int W = 8,
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int SW = $clog2(LANES * DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  width_e             wide,
    input  logic               word_push,
    input  logic [LANES*W-1:0] word_din,
    input  logic               byte_push,
    input  logic [W-1:0]       byte_din,
    input  logic               ser_pop,
    output logic               ser_valid,
    output logic [W-1:0]       ser_data,
    output logic               full,
    output logic               half,
    output logic               empty
);

    logic [LANES-1:0] l_push, l_pop, l_empty, l_full;
    logic [W-1:0]     l_din  [LANES];
    logic [W-1:0]     l_dout [LANES];
    logic [CW-1:0]    l_cnt  [LANES];
    logic [SELW-1:0]  sel;
    logic [SW-1:0]    total;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign l_push[g] = word_push || ((g == 0) && byte_push);
        assign l_din[g]  = word_push ? word_din[g*W +: W] : byte_din;
        assign l_pop[g]  = ser_pop && ser_valid && !clr && (sel == SELW'(g));

        qlf_lane #(.W(W), .DEPTH(DEPTH)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .push (l_push[g]),
            .din  (l_din[g]),
            .pop  (l_pop[g]),
            .dout (l_dout[g]),
            .cnt  (l_cnt[g]),
            .empty(l_empty[g]),
            .full (l_full[g])
        );
    end

    assign ser_valid = !l_empty[sel];
    assign ser_data  = l_dout[sel];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sel <= '0;
        end else if (ser_pop && ser_valid) begin
            sel <= SELW'(lane_after(int'(sel), LANES, wide));
        end
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < LANES; i++) begin
            total = total + SW'(l_cnt[i]);
        end
    end

    assign full  = (wide == W_WORD) ? |l_full : l_full[0];
    assign half  = (wide == W_WORD) ? (total >= SW'(LANES * DEPTH / 2))
                                    : (l_cnt[0] >= CW'(DEPTH / 2));
    assign empty = &l_empty;

endmodule

// File: rtl/qlf_rx_path.sv
module qlf_rx_path
    import qlf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int W = 8,
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int SELW = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  width_e             wide,
    input  logic               ser_push,
    input  logic [W-1:0]       ser_din,
    output logic               ser_ready,
    input  logic               word_pop,
    input  logic               byte_pop,
    output logic [LANES*W-1:0] word_dout,
    output logic [W-1:0]       byte_dout,
    output logic               word_avail,
    output logic               byte_avail
);

    logic [LANES-1:0] l_push, l_pop, l_empty, l_full;
    logic [W-1:0]     l_dout [LANES];
    logic [CW-1:0]    l_cnt  [LANES];
    logic [SELW-1:0]  sel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign l_push[g] = ser_push && ser_ready && !clr && (sel == SELW'(g));
        assign l_pop[g]  = word_pop || ((g == 0) && byte_pop);
        assign word_dout[g*W +: W] = l_dout[g];

        qlf_lane #(.W(W), .DEPTH(DEPTH)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .push (l_push[g]),
            .din  (ser_din),
            .pop  (l_pop[g]),
            .dout (l_dout[g]),
            .cnt  (l_cnt[g]),
            .empty(l_empty[g]),
            .full (l_full[g])
        );

        p_rx_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
            l_cnt[g] <= CW'(DEPTH));
    end

    assign ser_ready  = !l_full[sel];
    assign byte_dout  = l_dout[0];
    assign word_avail = ~|l_empty;
    assign byte_avail = !l_empty[0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sel <= '0;
        end else if (ser_push && ser_ready) begin
            sel <= SELW'(lane_after(int'(sel), LANES, wide));
        end
    end

    p_push_gives_byte_r5: assert property (@(posedge clk) disable iff (rst)
        (ser_push && ser_ready && !clr && sel == '0) |=> byte_avail);

endmodule

// File: rtl/quad_lane_fifo.sv
module quad_lane_fifo
    import qlf_pkg::*;
#(
    parameter int LANES = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF,
    parameter int DEPTH = DEPTH_DEF,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_clr,
    input  logic              word_mode,
    input  logic              wr_word_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              wr_byte_en,
    input  logic [LANE_W-1:0] wr_byte,
    output logic              tx_full,
    output logic              tx_half,
    output logic              tx_empty,
    input  logic              ser_tx_pop,
    output logic              ser_tx_valid,
    output logic [LANE_W-1:0] ser_tx_data,
    input  logic              ser_rx_push,
    input  logic [LANE_W-1:0] ser_rx_data,
    output logic              ser_rx_ready,
    input  logic              rd_word_en,
    output logic [WORD_W-1:0] rd_word,
    input  logic              rd_byte_en,
    output logic [LANE_W-1:0] rd_byte,
    output logic              rx_word_avail,
    output logic              rx_byte_avail,
    output logic              illegal
);

    width_e   mode;
    acc_bad_t bad;
    logic     word_push, byte_push, word_pop, byte_pop;
    logic     illegal_q;

    assign mode = word_mode ? W_WORD : W_BYTE;

    always_comb begin
        bad.wr_word = wr_word_en && ((mode != W_WORD) || tx_full);
        bad.wr_byte = wr_byte_en && ((mode != W_BYTE) || tx_full);
        bad.rd_word = rd_word_en && ((mode != W_WORD) || !rx_word_avail);
        bad.rd_byte = rd_byte_en && ((mode != W_BYTE) || !rx_byte_avail);
    end

    assign word_push = wr_word_en && !bad.wr_word && !soft_clr;
    assign byte_push = wr_byte_en && !bad.wr_byte && !soft_clr;
    assign word_pop  = rd_word_en && !bad.rd_word && !soft_clr;
    assign byte_pop  = rd_byte_en && !bad.rd_byte && !soft_clr;

    always_ff @(posedge clk) begin
        if (rst) illegal_q <= 1'b0;
        else     illegal_q <= !soft_clr && (|bad);
    end
    assign illegal = illegal_q;

    qlf_tx_path #(.LANES(LANES), .W(LANE_W), .DEPTH(DEPTH)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .clr      (soft_clr),
        .wide     (mode),
        .word_push(word_push),
        .word_din (wr_word),
        .byte_push(byte_push),
        .byte_din (wr_byte),
        .ser_pop  (ser_tx_pop),
        .ser_valid(ser_tx_valid),
        .ser_data (ser_tx_data),
        .full     (tx_full),
        .half     (tx_half),
        .empty    (tx_empty)
    );

    qlf_rx_path #(.LANES(LANES), .W(LANE_W), .DEPTH(DEPTH)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .clr       (soft_clr),
        .wide      (mode),
        .ser_push  (ser_rx_push),
        .ser_din   (ser_rx_data),
        .ser_ready (ser_rx_ready),
        .word_pop  (word_pop),
        .byte_pop  (byte_pop),
        .word_dout (rd_word),
        .byte_dout (rd_byte),
        .word_avail(rx_word_avail),
        .byte_avail(rx_byte_avail)
    );

    p_bad_width_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_byte_en && word_mode && !soft_clr) |=> illegal);

    p_empty_read_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_byte_en && !rx_byte_avail && !soft_clr) |=> illegal);

    p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (tx_empty && !rx_byte_avail && !rx_word_avail && !illegal));

    p_empty_no_stream_r2: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> !ser_tx_valid);

endmodule

// File: tb/quad_lane_fifo_test.sv
module quad_lane_fifo_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_clr = 1'b0, word_mode = 1'b0;
    logic        wr_word_en = 1'b0, wr_byte_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic [7:0]  wr_byte = '0;
    logic        tx_full, tx_half, tx_empty;
    logic        ser_tx_pop = 1'b0, ser_tx_valid;
    logic [7:0]  ser_tx_data;
    logic        ser_rx_push = 1'b0, ser_rx_ready;
    logic [7:0]  ser_rx_data = '0;
    logic        rd_word_en = 1'b0, rd_byte_en = 1'b0;
    logic [31:0] rd_word;
    logic [7:0]  rd_byte;
    logic        rx_word_avail, rx_byte_avail, illegal;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    quad_lane_fifo uut (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .word_mode(word_mode),
        .wr_word_en(wr_word_en), .wr_word(wr_word),
        .wr_byte_en(wr_byte_en), .wr_byte(wr_byte),
        .tx_full(tx_full), .tx_half(tx_half), .tx_empty(tx_empty),
        .ser_tx_pop(ser_tx_pop), .ser_tx_valid(ser_tx_valid), .ser_tx_data(ser_tx_data),
        .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data), .ser_rx_ready(ser_rx_ready),
        .rd_word_en(rd_word_en), .rd_word(rd_word),
        .rd_byte_en(rd_byte_en), .rd_byte(rd_byte),
        .rx_word_avail(rx_word_avail), .rx_byte_avail(rx_byte_avail),
        .illegal(illegal)
    );

    // Reference model: four circular byte queues per direction
    logic [7:0] tmem [4][16];
    logic [7:0] rmem [4][16];
    int tcnt [4], thd [4], rcnt [4], rhd [4];
    int tsel = 0, rsel = 0;
    bit exp_ill = 0;

    function automatic void m_clear();
        for (int i = 0; i < 4; i++) begin
            tcnt[i] = 0; thd[i] = 0; rcnt[i] = 0; rhd[i] = 0;
        end
        tsel = 0; rsel = 0;
    endfunction

    function automatic int next_sel(int s, bit m);
        if (!m) return 0;
        return (s + 1) % 4;
    endfunction

    function automatic bit m_tx_full(bit m);
        if (!m) return tcnt[0] == 16;
        return (tcnt[0] == 16) || (tcnt[1] == 16) || (tcnt[2] == 16) || (tcnt[3] == 16);
    endfunction

    function automatic bit m_tx_half(bit m);
        if (!m) return tcnt[0] >= 8;
        return (tcnt[0] + tcnt[1] + tcnt[2] + tcnt[3]) >= 32;
    endfunction

    function automatic bit m_word_avail();
        return (rcnt[0] > 0) && (rcnt[1] > 0) && (rcnt[2] > 0) && (rcnt[3] > 0);
    endfunction

    function automatic logic [31:0] m_rx_word();
        return {rmem[3][rhd[3]], rmem[2][rhd[2]], rmem[1][rhd[1]], rmem[0][rhd[0]]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs();
        bit tv;
        chk("R1 R6 tx_full", 32'(tx_full), 32'(m_tx_full(word_mode)));
        chk("R6 tx_half", 32'(tx_half), 32'(m_tx_half(word_mode)));
        chk("R6 tx_empty", 32'(tx_empty),
            32'((tcnt[0] + tcnt[1] + tcnt[2] + tcnt[3]) == 0));
        tv = tcnt[tsel] > 0;
        chk("R2 R3 ser_tx_valid", 32'(ser_tx_valid), 32'(tv));
        if (tv) chk("R2 R3 ser_tx_data", 32'(ser_tx_data), 32'(tmem[tsel][thd[tsel]]));
        chk("R9 ser_rx_ready", 32'(ser_rx_ready), 32'(rcnt[rsel] < 16));
        chk("R4 rx_word_avail", 32'(rx_word_avail), 32'(m_word_avail()));
        if (m_word_avail()) chk("R4 rd_word", rd_word, m_rx_word());
        chk("R5 rx_byte_avail", 32'(rx_byte_avail), 32'(rcnt[0] > 0));
        if (rcnt[0] > 0) chk("R5 rd_byte", 32'(rd_byte), 32'(rmem[0][rhd[0]]));
        chk("R7 R8 illegal", 32'(illegal), 32'(exp_ill));
    endtask

    // One clock: check at the falling edge, drive, update the model, advance.
    task automatic cycle(input bit ww, input logic [31:0] wwd, input bit wb,
                         input logic [7:0] wbd, input bit tp, input bit rp,
                         input logic [7:0] rpd, input bit rw, input bit rb,
                         input bit clr);
        bit m, full_pre, wavail_pre, bavail_pre, tvalid_pre, rready_pre;
        check_outputs();
        wr_word_en = ww; wr_word = wwd; wr_byte_en = wb; wr_byte = wbd;
        ser_tx_pop = tp; ser_rx_push = rp; ser_rx_data = rpd;
        rd_word_en = rw; rd_byte_en = rb; soft_clr = clr;
        m = word_mode;
        exp_ill = 0;
        if (clr) begin
            m_clear();
        end else begin
            full_pre = m_tx_full(m);
            wavail_pre = m_word_avail();
            bavail_pre = rcnt[0] > 0;
            tvalid_pre = tcnt[tsel] > 0;
            rready_pre = rcnt[rsel] < 16;
            if (ww && (!m || full_pre)) exp_ill = 1;
            if (wb && (m || full_pre)) exp_ill = 1;
            if (rw && (!m || !wavail_pre)) exp_ill = 1;
            if (rb && (m || !bavail_pre)) exp_ill = 1;
            // pops first (pre-state decides), then pushes
            if (tp && tvalid_pre) begin
                thd[tsel] = (thd[tsel] + 1) % 16; tcnt[tsel]--;
                tsel = next_sel(tsel, m);
            end
            if (rw && m && wavail_pre) begin
                for (int i = 0; i < 4; i++) begin
                    rhd[i] = (rhd[i] + 1) % 16; rcnt[i]--;
                end
            end
            if (rb && !m && bavail_pre) begin
                rhd[0] = (rhd[0] + 1) % 16; rcnt[0]--;
            end
            if (ww && m && !full_pre) begin
                for (int i = 0; i < 4; i++) begin
                    tmem[i][(thd[i] + tcnt[i]) % 16] = wwd[i*8 +: 8]; tcnt[i]++;
                end
            end
            if (wb && !m && !full_pre) begin
                tmem[0][(thd[0] + tcnt[0]) % 16] = wbd; tcnt[0]++;
            end
            if (rp && rready_pre) begin
                rmem[rsel][(rhd[rsel] + rcnt[rsel]) % 16] = rpd; rcnt[rsel]++;
                rsel = next_sel(rsel, m);
            end
        end
        @(negedge clk);
    endtask

    task automatic idle();           cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic wr_w(input logic [31:0] d); cycle(1, d, 0, 0, 0, 0, 0, 0, 0, 0); endtask
    task automatic wr_b(input logic [7:0] d);  cycle(0, 0, 1, d, 0, 0, 0, 0, 0, 0); endtask
    task automatic tpop();           cycle(0, 0, 0, 0, 1, 0, 0, 0, 0, 0); endtask
    task automatic rpush(input logic [7:0] d); cycle(0, 0, 0, 0, 0, 1, d, 0, 0, 0); endtask
    task automatic rdw();            cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, 0); endtask
    task automatic rdb();            cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 0); endtask
    task automatic clr_to(input bit m);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        word_mode = m;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        chk("R10 tx_empty", 32'(tx_empty), 1);
        chk("R10 tx_full", 32'(tx_full), 0);
        chk("R10 tx_half", 32'(tx_half), 0);
        chk("R10 rx_word_avail", 32'(rx_word_avail), 0);
        chk("R10 rx_byte_avail", 32'(rx_byte_avail), 0);
        chk("R10 ser_tx_valid", 32'(ser_tx_valid), 0);
        chk("R10 ser_rx_ready", 32'(ser_rx_ready), 1);
        chk("R10 illegal", 32'(illegal), 0);

        // R1 R2 word mode: fill 16 words, one extra, drain 64 bytes in lane order
        clr_to(1);
        for (int i = 0; i < 16; i++) wr_w({8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)});
        chk("R1 word capacity full", 32'(tx_full), 1);
        wr_w(32'hDEADBEEF);
        chk("R7 write when full", 32'(illegal), 1);
        wr_b(8'h55);
        for (int i = 0; i < 64; i++) begin
            chk("R2 lane order", 32'(ser_tx_data), 32'(i));
            tpop();
        end
        chk("R2 drained", 32'(tx_empty), 1);

        // R3 byte mode: capacity 16 on lane 0
        clr_to(0);
        for (int i = 0; i < 16; i++) wr_b(8'(8'hA0 + i));
        chk("R1 byte capacity full", 32'(tx_full), 1);
        wr_b(8'hFF);
        wr_w(32'h11223344);
        for (int i = 0; i < 16; i++) begin
            chk("R3 byte order", 32'(ser_tx_data), 32'(8'hA0 + i));
            tpop();
        end

        // R4 receive word assembly
        clr_to(1);
        rpush(8'h10); rpush(8'h20); rpush(8'h30);
        rdw();
        rpush(8'h40);
        chk("R4 word assembled", rd_word, 32'h40302010);
        rdw();
        rdb();

        // R5 R9 receive byte mode, fill to 16 then one more
        clr_to(0);
        for (int i = 0; i < 17; i++) rpush(8'(8'h60 + i));
        chk("R9 ready low at full", 32'(ser_rx_ready), 0);
        for (int i = 0; i < 17; i++) rdb();

        // R8 clear with pending data and a same-cycle write
        wr_b(8'h01); rpush(8'h02);
        cycle(0, 0, 1, 8'h03, 1, 1, 8'h04, 0, 1, 1);
        chk("R8 cleared tx", 32'(tx_empty), 1);
        chk("R8 cleared rx", 32'(rx_byte_avail), 0);
        idle();

        // Random phases: write-heavy then drain-heavy segments
        for (int seg = 0; seg < 12; seg++) begin
            int wp = (seg % 2 == 0) ? 7 : 2;
            for (int c = 0; c < 300; c++) begin
                bit m = word_mode;
                bit ww = m && ($urandom_range(0, 9) < wp);
                bit wb = !m && ($urandom_range(0, 9) < wp);
                bit tp = $urandom_range(0, 9) < (10 - wp);
                bit rp = $urandom_range(0, 9) < wp;
                bit rw = m && ($urandom_range(0, 9) < (10 - wp));
                bit rb = !m && ($urandom_range(0, 9) < (10 - wp));
                bit cl = ($urandom_range(0, 399) == 0);
                if ($urandom_range(0, 49) == 0) begin
                    wb = ~wb; rw = ~rw;
                end
                cycle(ww, $urandom, wb, 8'($urandom), tp, rp, 8'($urandom), rw, rb, cl);
                if (cl) word_mode = 1'($urandom_range(0, 1));
            end
            clr_to(1'($urandom_range(0, 1)));
        end
        idle();
        check_outputs();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule